// File: doc/BRIEF.md
# Event-Driven PWM Generator

This block is one pulse-width-modulation channel pair. A 16-bit timer runs either as a down counter that reloads from a programmable limit, or as an up/down counter that climbs from zero to the limit and falls back. From the timer state it derives a direction flag, a zero pulse, a limit pulse and two compare-match pulses. The two outputs are each shaped by an action word. For every event (zero, limit, compare A rising, compare A falling, compare B rising, compare B falling), the word says whether the output holds, toggles, goes low or goes high.

Count-down mode gives left- or right-aligned waveforms. Up/down mode gives centre-aligned ones. A synchronous clear input lets several such generators restart together, so that they share one time base. While the run enable is low, the whole channel stays parked at zero.

Top module: `pwm_evgen`

## Requirements
- R1: In count-down mode (`mode_updown`=0) the counter steps down by one each clock. The cycle after it reads zero, it reloads `load_val`, so that zero pulses recur every `load_val`+1 clocks.
- R2: In up/down mode (`mode_updown`=1) the counter climbs by one per clock up to `load_val`, then descends to zero, then climbs again. Zero pulses recur every 2*`load_val` clocks.
- R3: `dir` is 1 when the current count was reached by an upward step and 0 when it was reached by a downward step. It is 0 after reset, after a clear and in count-down mode, and it is 1 on the cycle where the count equals `load_val` in up/down mode.
- R4: While running, `zero_p` is high exactly on cycles where the counter is 0, and `load_p` is high exactly on cycles where the counter equals `load_val`.
- R5: While running, `cmpa_p` (`cmpb_p`) is high exactly on cycles where the counter equals `cmp_a_val` (`cmp_b_val`).
- R6: Each output has a 12-bit action word (`act_a_cfg`, `act_b_cfg`) with 2-bit fields. The fields are zero in [1:0], limit in [3:2], A-up in [5:4], A-down in [7:6], B-up in [9:8] and B-down in [11:10]. The codes are 00 hold, 01 toggle, 10 drive low and 11 drive high. The output takes the effect of an event on the clock after the event cycle.
- R7: A compare match is an "up" event when `dir` is 1 and a "down" event when `dir` is 0. Therefore only zero, limit, A-down and B-down ever act in count-down mode.
- R8: When several events with non-hold codes coincide, B events win over A events, A events win over the limit event, and the limit event wins over the zero event. An event coded hold never overrides another event.
- R9: When `sync_clr` is high during a running clock, the counter reads 0 with `dir`=0 on the next cycle. It then proceeds as after a start: in count-down mode it reloads, and in up/down mode it climbs.
- R10: While `run_en` is low, the counter, `dir` and both outputs are cleared on each clock, and all four pulses stay low.
- R11: After reset (`rst_n` low, asynchronous), every output is 0.
- R12: In count-down mode with limit 39, if A goes high on limit and low on A-down at compare 29, A is high 10 of every 40 clocks. If B goes high on limit and low on B-down at compare 9, B is high 30 of every 40 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable; low parks the channel |
| mode_updown | input | 1 | 0 count-down, 1 up/down |
| sync_clr | input | 1 | Synchronous counter clear for alignment |
| load_val | input | 16 | Counter limit |
| cmp_a_val | input | 16 | Compare value A |
| cmp_b_val | input | 16 | Compare value B |
| act_a_cfg | input | 12 | Action word for output A |
| act_b_cfg | input | 12 | Action word for output B |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| dir | output | 1 | Count direction |
| zero_p | output | 1 | Counter-at-zero pulse |
| load_p | output | 1 | Counter-at-limit pulse |
| cmpa_p | output | 1 | Compare A match pulse |
| cmpb_p | output | 1 | Compare B match pulse |

## Verification
The hardest situation to reach is two or three events with non-hold codes landing on the same clock, in both directions. This is where the priority order decides the output. Directed phases place compare values on zero and on the limit, in both modes, so that coincidences are certain. A long random phase then uses small limits and compare values drawn from the limit range, so that coincidences recur often. Mode switches, clears and run drops arrive mid-period, which catches state left over from the other mode.

// File: rtl/pwm_evgen_pkg.sv
package pwm_evgen_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } act_e;

    // event slots, ascending priority
    localparam int EV_ZERO = 0;
    localparam int EV_LOAD = 1;
    localparam int EV_AUP  = 2;
    localparam int EV_ADN  = 3;
    localparam int EV_BUP  = 4;
    localparam int EV_BDN  = 5;
    localparam int NUM_EV  = 6;
    localparam int ACT_W   = 2;
    localparam int CFG_W   = NUM_EV * ACT_W;
    localparam int NUM_CMP = 2;
endpackage

// File: rtl/pwm_evgen_timer.sv
module pwm_evgen_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             mode_updown,
    input  logic             sync_clr,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             dir,
    output logic             ev_zero,
    output logic             ev_load
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_en || sync_clr) begin
            st_d.cnt = '0;
            st_d.dir = 1'b0;
        end else if (!mode_updown) begin
            st_d.dir = 1'b0;
            st_d.cnt = (st_q.cnt == '0) ? load_val : st_q.cnt - ONE;
        end else if (st_q.dir) begin
            if (st_q.cnt >= load_val) begin
                st_d.dir = 1'b0;
                st_d.cnt = (st_q.cnt == '0) ? '0 : st_q.cnt - ONE;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end else if (st_q.cnt == '0) begin
            st_d.dir = (load_val != '0);
            st_d.cnt = (load_val == '0) ? '0 : ONE;
        end else begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign dir     = st_q.dir;
    assign ev_zero = run_en && (st_q.cnt == '0);
    assign ev_load = run_en && (st_q.cnt == load_val);

    // R1
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !mode_updown && !sync_clr && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - ONE));
    // R2
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && mode_updown && !sync_clr && st_q.dir && st_q.cnt < load_val) |=> (st_q.cnt == $past(st_q.cnt) + ONE));
    // R3
    down_mode_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_updown) |=> !st_q.dir);
    // R9
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr |=> (st_q.cnt == '0 && !st_q.dir));
    // R10
    park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en) |=> (st_q.cnt == '0 && !st_q.dir));
endmodule

// File: rtl/pwm_evgen_match.sv
module pwm_evgen_match #(
    parameter int CNT_W = 16
) (
    input  logic             run_en,
    input  logic [CNT_W-1:0] cnt,
    input  logic             dir,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             hit,
    output logic             hit_up,
    output logic             hit_dn
);
    always_comb begin
        hit    = run_en && (cnt == cmp_val);
        hit_up = hit && dir;
        hit_dn = hit && !dir;
    end
endmodule

// File: rtl/pwm_evgen_action.sv
module pwm_evgen_action
    import pwm_evgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [NUM_EV-1:0] ev,
    input  logic [CFG_W-1:0]  cfg,
    output logic              pwm
);
    typedef struct packed {
        logic lvl;
    } act_st_t;

    act_st_t st_d, st_q;
    act_e    win;

    // later slots overwrite earlier ones: B > A > load > zero
    always_comb begin
        win = ACT_HOLD;
        for (int i = 0; i < NUM_EV; i++) begin
            if (ev[i] && act_e'(cfg[i*ACT_W +: ACT_W]) != ACT_HOLD)
                win = act_e'(cfg[i*ACT_W +: ACT_W]);
        end
    end

    always_comb begin
        st_d = st_q;
        if (!run_en) begin
            st_d.lvl = 1'b0;
        end else begin
            unique case (win)
                ACT_TOGGLE: st_d.lvl = !st_q.lvl;
                ACT_LOW:    st_d.lvl = 1'b0;
                ACT_HIGH:   st_d.lvl = 1'b1;
                default:    st_d.lvl = st_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm = st_q.lvl;

    // R6
    drive_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && win == ACT_HIGH) |=> pwm);
    // R6
    drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && win == ACT_LOW) |=> !pwm);
    // R6
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && win == ACT_TOGGLE) |=> (pwm != $past(pwm)));
    // R8
    b_down_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[EV_BDN] && cfg[EV_BDN*ACT_W +: ACT_W] != 2'b00) |-> (win == act_e'(cfg[EV_BDN*ACT_W +: ACT_W])));
    // R10
    parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en) |=> !pwm);
endmodule

// File: rtl/pwm_evgen.sv
module pwm_evgen
    import pwm_evgen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             mode_updown,
    input  logic             sync_clr,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] cmp_a_val,
    input  logic [CNT_W-1:0] cmp_b_val,
    input  logic [CFG_W-1:0] act_a_cfg,
    input  logic [CFG_W-1:0] act_b_cfg,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic             dir,
    output logic             zero_p,
    output logic             load_p,
    output logic             cmpa_p,
    output logic             cmpb_p
);
    logic [CNT_W-1:0] cnt;
    logic             ev_zero, ev_load;
    logic [CNT_W-1:0] cmp_vals [NUM_CMP];
    logic [NUM_CMP-1:0] hit, hit_up, hit_dn;
    logic [CFG_W-1:0] cfgs [2];
    logic [1:0]       pwm_o;
    logic [NUM_EV-1:0] ev;

    assign cmp_vals[0] = cmp_a_val;
    assign cmp_vals[1] = cmp_b_val;
    assign cfgs[0]     = act_a_cfg;
    assign cfgs[1]     = act_b_cfg;

    pwm_evgen_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_updown(mode_updown),
        .sync_clr(sync_clr), .load_val(load_val), .cnt(cnt), .dir(dir),
        .ev_zero(ev_zero), .ev_load(ev_load)
    );

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        pwm_evgen_match #(.CNT_W(CNT_W)) match_i (
            .run_en(run_en), .cnt(cnt), .dir(dir), .cmp_val(cmp_vals[c]),
            .hit(hit[c]), .hit_up(hit_up[c]), .hit_dn(hit_dn[c])
        );
    end

    always_comb begin
        ev          = '0;
        ev[EV_ZERO] = ev_zero;
        ev[EV_LOAD] = ev_load;
        ev[EV_AUP]  = hit_up[0];
        ev[EV_ADN]  = hit_dn[0];
        ev[EV_BUP]  = hit_up[1];
        ev[EV_BDN]  = hit_dn[1];
    end

    for (genvar o = 0; o < 2; o++) begin : g_out
        pwm_evgen_action act_i (
            .clk(clk), .rst_n(rst_n), .run_en(run_en), .ev(ev),
            .cfg(cfgs[o]), .pwm(pwm_o[o])
        );
    end

    assign pwm_a  = pwm_o[0];
    assign pwm_b  = pwm_o[1];
    assign zero_p = ev_zero;
    assign load_p = ev_load;
    assign cmpa_p = hit[0];
    assign cmpb_p = hit[1];

    // R7
    no_up_in_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !mode_updown && !$past(mode_updown)) |-> !(ev[EV_AUP] || ev[EV_BUP]));
    // R10
    quiet_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en) |-> !(zero_p || load_p || cmpa_p || cmpb_p));
endmodule

// File: tb/pwm_evgen_tb_top.sv
module pwm_evgen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0, mode_updown = 1'b0, sync_clr = 1'b0;
    logic [15:0] load_val = '0, cmp_a_val = '0, cmp_b_val = '0;
    logic [11:0] act_a_cfg = '0, act_b_cfg = '0;
    logic        pwm_a, pwm_b, dir, zero_p, load_p, cmpa_p, cmpb_p;

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;
    int  m_cnt = 0;
    bit  m_dir = 0, m_pa = 0, m_pb = 0;

    always #4 clk = ~clk;

    pwm_evgen dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_updown(mode_updown),
        .sync_clr(sync_clr), .load_val(load_val), .cmp_a_val(cmp_a_val),
        .cmp_b_val(cmp_b_val), .act_a_cfg(act_a_cfg), .act_b_cfg(act_b_cfg),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .dir(dir), .zero_p(zero_p),
        .load_p(load_p), .cmpa_p(cmpa_p), .cmpb_p(cmpb_p)
    );

    task automatic chk(string req, logic act, logic exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_int(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // highest-priority non-hold event, searched from the top
    function automatic bit next_lvl(bit cur, bit [11:0] cfg, bit [5:0] evs);
        int code = 0;
        for (int k = 5; k >= 0; k--) begin
            if (evs[k] && cfg[2*k +: 2] != 2'b00) begin
                code = int'(cfg[2*k +: 2]);
                break;
            end
        end
        case (code)
            1: return !cur;
            2: return 1'b0;
            3: return 1'b1;
            default: return cur;
        endcase
    endfunction

    // reference model, compared on every clock
    always @(posedge clk) begin
        bit z, l, ma, mb;
        bit [5:0] evs;
        z  = run_en && m_cnt == 0;
        l  = run_en && m_cnt == int'(load_val);
        ma = run_en && m_cnt == int'(cmp_a_val);
        mb = run_en && m_cnt == int'(cmp_b_val);
        evs = {mb && !m_dir, mb && m_dir, ma && !m_dir, ma && m_dir, l, z};
        if (!rst_n || !run_en) begin
            m_cnt = 0; m_dir = 0; m_pa = 0; m_pb = 0;
        end else begin
            m_pa = next_lvl(m_pa, act_a_cfg, evs);
            m_pb = next_lvl(m_pb, act_b_cfg, evs);
            if (sync_clr) begin
                m_cnt = 0; m_dir = 0;
            end else if (!mode_updown) begin
                m_dir = 0;
                m_cnt = (m_cnt == 0) ? int'(load_val) : m_cnt - 1;
            end else if (m_dir) begin
                if (m_cnt >= int'(load_val)) begin
                    m_dir = 0;
                    if (m_cnt > 0) m_cnt--;
                end else m_cnt++;
            end else if (m_cnt == 0) begin
                if (load_val != 0) begin m_dir = 1; m_cnt = 1; end
            end else m_cnt--;
        end
        #2;
        if (rst_n && !done) begin
            chk("R6", pwm_a, m_pa, "pwm_a");
            chk("R6", pwm_b, m_pb, "pwm_b");
            chk("R3", dir, m_dir, "dir");
            chk("R4", zero_p, run_en && m_cnt == 0, "zero_p");
            chk("R4", load_p, run_en && m_cnt == int'(load_val), "load_p");
            chk("R5", cmpa_p, run_en && m_cnt == int'(cmp_a_val), "cmpa_p");
            chk("R5", cmpb_p, run_en && m_cnt == int'(cmp_b_val), "cmpb_p");
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic restart();
        @(negedge clk); run_en = 1'b0;
        @(negedge clk); run_en = 1'b1;
    endtask

    task automatic zero_period(output int per);
        per = 0;
        while (!zero_p) step(1);
        step(1); per = 1;
        while (!zero_p && per < 1000) begin step(1); per++; end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int per, hi_a, hi_b, bad;
        step(2);
        // R11 reset state
        chk("R11", pwm_a | pwm_b | dir, 1'b0, "outputs in reset");
        chk("R11", zero_p | load_p | cmpa_p | cmpb_p, 1'b0, "pulses in reset");
        @(negedge clk); rst_n = 1'b1;

        // R1 / R12 count-down duty example
        load_val = 16'd39; cmp_a_val = 16'd29; cmp_b_val = 16'd9;
        act_a_cfg = 12'h08C; act_b_cfg = 12'h80C; mode_updown = 1'b0;
        restart();
        zero_period(per);
        chk_int("R1", per, 40, "count-down period");
        hi_a = 0; hi_b = 0;
        for (int i = 0; i < 40; i++) begin
            step(1); hi_a += pwm_a; hi_b += pwm_b;
        end
        chk_int("R12", hi_a, 10, "A high clocks per period");
        chk_int("R12", hi_b, 30, "B high clocks per period");

        // R9 sync clear
        step(7);
        @(negedge clk); sync_clr = 1'b1;
        step(1);
        chk("R9", zero_p, 1'b1, "zero after clear");
        @(negedge clk); sync_clr = 1'b0;
        step(1);
        chk("R9", load_p, 1'b1, "reload after clear");

        // R10 park
        @(negedge clk); run_en = 1'b0;
        step(1);
        chk("R10", pwm_a | pwm_b | dir | zero_p | load_p | cmpa_p | cmpb_p, 1'b0, "parked outputs");
        step(3);
        chk("R10", pwm_a | pwm_b | zero_p, 1'b0, "still parked");

        // R2 / R3 up/down centre-aligned
        @(negedge clk);
        mode_updown = 1'b1; load_val = 16'd20; cmp_a_val = 16'd5; cmp_b_val = 16'd15;
        act_a_cfg = 12'h0B0; act_b_cfg = 12'h005; run_en = 1'b1;
        zero_period(per);
        chk_int("R2", per, 40, "up/down period");
        while (!load_p) step(1);
        chk("R3", dir, 1'b1, "dir at limit");
        step(1);
        chk("R3", dir, 1'b0, "dir after limit");
        step(100);

        // R7 up actions ignored in count-down
        @(negedge clk); mode_updown = 1'b0; act_a_cfg = 12'h330; act_b_cfg = 12'h330;
        cmp_a_val = 16'd10; cmp_b_val = 16'd3;
        restart();
        bad = 0;
        for (int i = 0; i < 100; i++) begin step(1); bad += pwm_a + pwm_b; end
        chk_int("R7", bad, 0, "output moves on up events in count-down");

        // R8 coincidences: A-down at zero beats zero-high; B-down at limit beats load toggle
        @(negedge clk); load_val = 16'd15; cmp_a_val = 16'd0; cmp_b_val = 16'd15;
        act_a_cfg = 12'h083; act_b_cfg = 12'hC04;
        restart();
        while (!zero_p) step(1);
        step(1);
        chk("R8", pwm_a, 1'b0, "compare beats zero");
        while (!load_p) step(1);
        step(1);
        chk("R8", pwm_b, 1'b1, "compare beats load");
        // hold code does not override: B-down hold, A-down high at same count
        @(negedge clk); cmp_b_val = 16'd0; act_b_cfg = 12'h0C0; act_a_cfg = 12'h0C0;
        step(40);
        // up/down: A-up high vs B-up low at same count
        @(negedge clk); mode_updown = 1'b1; cmp_a_val = 16'd7; cmp_b_val = 16'd7;
        act_a_cfg = 12'h230; act_b_cfg = 12'h230;
        step(80);

        // random phase, checked by the model every clock
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (($urandom % 40) == 0) mode_updown = $urandom % 2;
            if (($urandom % 60) == 0) load_val = 16'($urandom % 24);
            if (($urandom % 30) == 0) cmp_a_val = 16'($urandom % 26);
            if (($urandom % 30) == 0) cmp_b_val = 16'($urandom % 26);
            if (($urandom % 50) == 0) act_a_cfg = 12'($urandom);
            if (($urandom % 50) == 0) act_b_cfg = 12'($urandom);
            sync_clr = (($urandom % 90) == 0);
            run_en   = (($urandom % 120) != 0);
        end
        @(negedge clk); sync_clr = 1'b0;
        step(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule